// File: doc/BRIEF.md
# Selectable-Polynomial Frame Check Sequence Verifier

This block sits in the receive path of a bit-oriented serial link, after flag recognition and zero-bit removal. It sees every destuffed byte that lies between an opening and a closing flag, folds each byte into a running check register, and at the closing flag reports whether the frame's check sequence was intact. Three algorithms are available at run time: a 16-bit code with generator 0x1021, a 16-bit code with generator 0x8005, and a 32-bit code with generator 0x04C11DB7. All three are processed least significant bit first.

The check bytes are not removed. Every byte, payload and check sequence alike, is passed on unchanged to the next stage of the receive path one cycle after it arrives. The verifier cannot be switched off. It produces a result for every frame, and software that does not care about frame integrity simply ignores the error bit.

A frame is bracketed by a one-cycle `frameStart` pulse, which presets the register and latches the algorithm select, and a one-cycle `frameEnd` pulse, which triggers the comparison. A byte may arrive in the same cycle as `frameEnd` and is included in the check. A new `frameStart` without a preceding `frameEnd` drops the unfinished frame.

Top module: `crcchk_top`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `checkDone`, `crcErr` and `fwdValid` are 0.
- R2: `crcSel` = 0 selects the 16-bit 0x1021 code: preset 0xFFFF, LSB first. A frame whose last two bytes carry the inverted register, low byte first, is reported with `crcErr` = 0 (residue 0xF0B8). Any single-bit corruption is reported with `crcErr` = 1.
- R3: `crcSel` = 1 selects the 16-bit 0x8005 code: preset 0x0000, LSB first, no inversion. A frame ending in its register low byte first gives `crcErr` = 0 (residue 0). A corrupted frame gives 1.
- R4: `crcSel` = 2 or 3 selects the 32-bit 0x04C11DB7 code: preset 0xFFFFFFFF, LSB first. A frame ending in the inverted register, least significant byte first, gives `crcErr` = 0 (residue 0xDEBB20E3). A corrupted frame gives 1.
- R5: `checkDone` is high for exactly the one cycle after each cycle in which `frameEnd` is high. `crcErr` is valid in that same cycle.
- R6: `crcErr` keeps its value until the cycle after the next `frameStart`, when it becomes 0.
- R7: The algorithm is taken from `crcSel` in the `frameStart` cycle. Changes to `crcSel` later in the frame have no effect on that frame's result.
- R8: Each byte with `byteValid` high appears on `fwdData` with `fwdValid` high one cycle later, unmodified, including the check bytes. `fwdValid` is 0 one cycle after a cycle with `byteValid` low.
- R9: The register is preset at every `frameStart`, so an abandoned frame (start with no end) does not affect the result of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteData | input | 8 | Destuffed received byte |
| byteValid | input | 1 | `byteData` holds a byte this cycle |
| frameStart | input | 1 | Opening flag seen, one-cycle pulse |
| frameEnd | input | 1 | Closing flag seen, one-cycle pulse |
| crcSel | input | 2 | Algorithm select: 0 = 0x1021, 1 = 0x8005, 2/3 = 32-bit |
| fwdData | output | 8 | Byte forwarded to the receive buffer |
| fwdValid | output | 1 | `fwdData` is valid |
| checkDone | output | 1 | One-cycle pulse, frame check result ready |
| crcErr | output | 1 | 1 = check sequence mismatch for the last frame |

## Verification
Every result is due one clock edge after its cause. A forwarded byte appears one edge after its input cycle. `checkDone` and the frame's `crcErr` appear one edge after the `frameEnd` cycle, and `crcErr` clears one edge after `frameStart`. The bench drives inputs on the falling edge and samples each result on the next falling edge, so exactly one rising edge lies between stimulus and check. It re-checks `crcErr` two idle cycles later to confirm the value holds. Expected results come from a bit-serial reference model that uses the algorithm latched at frame start, while `crcSel` is randomized during the frame.

// File: rtl/crcchk_pkg.sv
package crcchk_pkg;

  localparam int CRC_W = 32;

  typedef enum logic [1:0] {
    MODE_X1021 = 2'd0,
    MODE_X8005 = 2'd1,
    MODE_X32   = 2'd2
  } crcMode_t;

  typedef struct packed {
    logic     preset;
    logic     advance;
    logic     finish;
    crcMode_t mode;
  } ctrlStrobes_t;

  function automatic crcMode_t decodeSel(input logic [1:0] sel);
    case (sel)
      2'd0:    return MODE_X1021;
      2'd1:    return MODE_X8005;
      default: return MODE_X32;
    endcase
  endfunction

  // Reflected generator polynomials
  function automatic logic [CRC_W-1:0] modePoly(input crcMode_t m);
    case (m)
      MODE_X1021: return 32'h0000_8408;
      MODE_X8005: return 32'h0000_A001;
      default:    return 32'hEDB8_8320;
    endcase
  endfunction

  function automatic logic [CRC_W-1:0] modePreset(input crcMode_t m);
    case (m)
      MODE_X1021: return 32'h0000_FFFF;
      MODE_X8005: return 32'h0000_0000;
      default:    return 32'hFFFF_FFFF;
    endcase
  endfunction

  // Register content left by an intact frame
  function automatic logic [CRC_W-1:0] modeResidue(input crcMode_t m);
    case (m)
      MODE_X1021: return 32'h0000_F0B8;
      MODE_X8005: return 32'h0000_0000;
      default:    return 32'hDEBB_20E3;
    endcase
  endfunction

endpackage

// File: rtl/crcchk_ctrl.sv
module crcchk_ctrl
  import crcchk_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         frameStart,
  input  logic         frameEnd,
  input  logic         byteValid,
  input  logic [1:0]   crcSel,
  input  logic         crcMatch,
  output ctrlStrobes_t strobes,
  output logic         checkDone,
  output logic         crcErr
);

  crcMode_t heldMode;

  // Mode is captured at the opening flag and held for the frame
  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldMode <= MODE_X1021;
    end else if (frameStart) begin
      heldMode <= decodeSel(crcSel);
    end
  end

  always_comb begin
    strobes.preset  = frameStart;
    strobes.advance = byteValid;
    strobes.finish  = frameEnd;
    strobes.mode    = frameStart ? decodeSel(crcSel) : heldMode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      checkDone <= 1'b0;
      crcErr    <= 1'b0;
    end else begin
      checkDone <= strobes.finish;
      if (strobes.finish) begin
        crcErr <= !crcMatch;
      end else if (strobes.preset) begin
        crcErr <= 1'b0;
      end
    end
  end

  // R5: a closing flag yields a done pulse on the next cycle
  p_done_after_end_r5: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> checkDone);

  // R5: no done pulse without a closing flag
  p_no_spurious_done_r5: assert property (@(posedge clk) disable iff (!rstN)
    !frameEnd |=> !checkDone);

  // R6: error bit only moves at frame boundaries
  p_err_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!frameStart && !frameEnd) |=> $stable(crcErr));

  // R6: a new frame clears the error bit
  p_err_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && !frameEnd) |=> !crcErr);

  // R7: the latched mode does not move inside a frame
  p_mode_held_r7: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> $stable(heldMode));

endmodule

// File: rtl/crcchk_datapath.sv
module crcchk_datapath
  import crcchk_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] byteData,
  output logic              crcMatch,
  output logic [DATA_W-1:0] fwdData,
  output logic              fwdValid
);

  logic [CRC_W-1:0] crcReg;
  logic [CRC_W-1:0] baseVal;
  logic [CRC_W-1:0] stepped;
  logic [CRC_W-1:0] nextCrc;
  logic [CRC_W-1:0] poly;

  assign poly    = modePoly(strobes.mode);
  assign baseVal = strobes.preset ? modePreset(strobes.mode) : crcReg;

  // Bit-serial LSB-first division, unrolled over one byte
  always_comb begin
    logic fb;
    stepped = baseVal;
    for (int i = 0; i < DATA_W; i++) begin
      fb      = stepped[0] ^ byteData[i];
      stepped = {1'b0, stepped[CRC_W-1:1]} ^ (fb ? poly : '0);
    end
  end

  assign nextCrc  = strobes.advance ? stepped : baseVal;
  assign crcMatch = (nextCrc == modeResidue(strobes.mode));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg <= '0;
    end else if (strobes.preset || strobes.advance) begin
      crcReg <= nextCrc;
    end
  end

  // Pass-through toward the receive buffer, check bytes included
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fwdValid <= 1'b0;
      fwdData  <= '0;
    end else begin
      fwdValid <= strobes.advance;
      if (strobes.advance) begin
        fwdData <= byteData;
      end
    end
  end

  // R8: each accepted byte is forwarded unchanged one cycle later
  p_forward_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.advance |=> (fwdValid && fwdData == $past(byteData)));

  // R8: no forward without an input byte
  p_no_forward_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.advance |=> !fwdValid);

  // R2/R3: a 16-bit code never leaves bits in the upper half
  p_upper_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.preset && strobes.mode != MODE_X32) |-> (crcReg[CRC_W-1:16] == '0));

endmodule

// File: rtl/crcchk_top.sv
module crcchk_top
  import crcchk_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] byteData,
  input  logic              byteValid,
  input  logic              frameStart,
  input  logic              frameEnd,
  input  logic [1:0]        crcSel,
  output logic [DATA_W-1:0] fwdData,
  output logic              fwdValid,
  output logic              checkDone,
  output logic              crcErr
);

  ctrlStrobes_t strobes;
  logic         crcMatch;

  crcchk_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameStart (frameStart),
    .frameEnd   (frameEnd),
    .byteValid  (byteValid),
    .crcSel     (crcSel),
    .crcMatch   (crcMatch),
    .strobes    (strobes),
    .checkDone  (checkDone),
    .crcErr     (crcErr)
  );

  crcchk_datapath #(.DATA_W(DATA_W)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .byteData (byteData),
    .crcMatch (crcMatch),
    .fwdData  (fwdData),
    .fwdValid (fwdValid)
  );

  // R1: outputs quiet while in reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (!checkDone && !crcErr && !fwdValid));

endmodule

// File: tb/crcchk_top_bench.sv
module crcchk_top_bench;

  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] byteData;
  logic       byteValid;
  logic       frameStart;
  logic       frameEnd;
  logic [1:0] crcSel;
  logic [7:0] fwdData;
  logic       fwdValid;
  logic       checkDone;
  logic       crcErr;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  crcchk_top u_crcchk_top (
    .clk        (clk),
    .rstN       (rstN),
    .byteData   (byteData),
    .byteValid  (byteValid),
    .frameStart (frameStart),
    .frameEnd   (frameEnd),
    .crcSel     (crcSel),
    .fwdData    (fwdData),
    .fwdValid   (fwdValid),
    .checkDone  (checkDone),
    .crcErr     (crcErr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference model, written from the requirement text
  function automatic logic [31:0] refPoly(input int sel);
    if (sel == 0) return 32'h8408;
    if (sel == 1) return 32'hA001;
    return 32'hEDB88320;
  endfunction

  function automatic logic [31:0] refPreset(input int sel);
    if (sel == 0) return 32'hFFFF;
    if (sel == 1) return 32'h0;
    return 32'hFFFFFFFF;
  endfunction

  function automatic logic [31:0] refResidue(input int sel);
    if (sel == 0) return 32'hF0B8;
    if (sel == 1) return 32'h0;
    return 32'hDEBB20E3;
  endfunction

  function automatic logic [31:0] refInvert(input int sel);
    if (sel == 0) return 32'hFFFF;
    if (sel == 1) return 32'h0;
    return 32'hFFFFFFFF;
  endfunction

  function automatic int refBytes(input int sel);
    return (sel >= 2) ? 4 : 2;
  endfunction

  function automatic logic [31:0] refStep(input logic [31:0] c, input logic [7:0] b,
                                          input int sel);
    logic [31:0] r = c;
    for (int k = 0; k < 8; k++) begin
      if (r[0] ^ b[k]) r = (r >> 1) ^ refPoly(sel);
      else             r = r >> 1;
    end
    return r;
  endfunction

  function automatic string selTag(input int sel);
    if (sel == 0) return "R2";
    if (sel == 1) return "R3";
    return "R4";
  endfunction

  logic [7:0] buf8 [0:39];
  int         bufLen;

  // Build payload plus check sequence, optionally corrupt one bit
  task automatic buildFrame(input int sel, input int nPay, input bit corrupt,
                            output bit expErr);
    logic [31:0] c = refPreset(sel);
    logic [31:0] fcs;
    for (int i = 0; i < nPay; i++) begin
      buf8[i] = 8'($urandom);
      c = refStep(c, buf8[i], sel);
    end
    fcs = c ^ refInvert(sel);
    for (int i = 0; i < refBytes(sel); i++) buf8[nPay + i] = fcs[8*i +: 8];
    bufLen = nPay + refBytes(sel);
    if (corrupt) begin
      int pos = int'($urandom_range(bufLen - 1));
      buf8[pos] ^= 8'(1 << $urandom_range(7));
    end
    c = refPreset(sel);
    for (int i = 0; i < bufLen; i++) c = refStep(c, buf8[i], sel);
    expErr = (c != refResidue(sel));
  endtask

  // Drive one frame; crcSel is randomized after the start cycle (R7)
  task automatic sendFrame(input int sel, input int nPay, input bit corrupt,
                           input bit gaps);
    bit expErr;
    string tag = selTag(sel);
    buildFrame(sel, nPay, corrupt, expErr);
    @(negedge clk);
    frameStart = 1'b1; crcSel = 2'(sel); byteValid = 1'b0; frameEnd = 1'b0;
    @(negedge clk);
    frameStart = 1'b0;
    check(crcErr == 1'b0, "R6", "crcErr after frameStart", crcErr, 0);
    for (int i = 0; i < bufLen; i++) begin
      if (gaps && $urandom_range(3) == 0) begin
        byteValid = 1'b0; crcSel = 2'($urandom);
        @(negedge clk);
        check(fwdValid == 1'b0, "R8", "fwdValid on idle cycle", fwdValid, 0);
      end
      byteData = buf8[i]; byteValid = 1'b1; crcSel = 2'($urandom);
      @(negedge clk);
      check(fwdValid && fwdData == buf8[i], "R8", "forwarded byte",
            {fwdValid, fwdData}, {1'b1, buf8[i]});
    end
    byteValid = 1'b0; frameEnd = 1'b1; crcSel = 2'($urandom);
    @(negedge clk);
    frameEnd = 1'b0;
    check(checkDone == 1'b1, "R5", "checkDone after frameEnd", checkDone, 1);
    check(crcErr == expErr, tag, "crcErr at done (R7 select latched)", crcErr, expErr);
    @(negedge clk);
    check(checkDone == 1'b0, "R5", "checkDone pulse width", checkDone, 0);
    @(negedge clk);
    check(crcErr == expErr, "R6", "crcErr held after done", crcErr, expErr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    rstN = 1'b0; byteData = '0; byteValid = 1'b0;
    frameStart = 1'b0; frameEnd = 1'b0; crcSel = '0;
    repeat (3) @(negedge clk);
    check(!checkDone && !crcErr && !fwdValid, "R1", "outputs in reset",
          {checkDone, crcErr, fwdValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!checkDone && !crcErr && !fwdValid, "R1", "outputs after reset",
          {checkDone, crcErr, fwdValid}, 0);

    // Directed corners: FCS-only frames, each mode clean and corrupt, select 3
    for (int s = 0; s < 4; s++) sendFrame(s, 0, 1'b0, 1'b0);
    for (int s = 0; s < 3; s++) sendFrame(s, 5, 1'b1, 1'b0);
    sendFrame(3, 9, 1'b0, 1'b1);

    // R9: abandoned frame with no closing flag, then a clean frame
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      frameStart = 1'b1; crcSel = 2'(s);
      @(negedge clk);
      frameStart = 1'b0;
      for (int i = 0; i < 4; i++) begin
        byteData = 8'($urandom); byteValid = 1'b1;
        @(negedge clk);
      end
      byteValid = 1'b0;
      sendFrame(s, 6, 1'b0, 1'b0);
      check(crcErr == 1'b0, "R9", "clean frame after abandoned one", crcErr, 0);
    end

    // Constrained random frames
    for (int n = 0; n < 60; n++) begin
      sendFrame(int'($urandom_range(3)), int'($urandom_range(20)),
                ($urandom_range(2) == 0), 1'b1);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule